// File: doc/BRIEF.md
# Register Width Adapting Bridge

This block sits between a processor-side request port and a register block whose slots each have a fixed native width of one, two or four bytes. The processor may issue byte, word or long accesses at any offset in a 10-bit window. The bridge looks up the native width of the addressed slot in a per-slot table. It then turns the request into one or more native-width accesses on the register side, issued strictly one after another.

Three cases arise. When the request is wider than the slot, it is cut into native-width pieces, most significant first, at ascending addresses. When it is narrower, a read fetches the containing register and picks out the addressed big-endian lanes. A write in that case fetches the containing register, merges the new lanes, and writes the whole register back. Requests outside the mapped window, to a slot marked unmapped, or with an illegal size code end in an error response and touch no register.

Top module: `width_bridge`

## Requirements
- R1: Only the 10-bit offset `req_off` selects the target. Offsets at or above 0x200 give `rsp_err`=1 and make no register-side access.
- R2: The native width of an offset comes from table entry `req_off>>2`, coded 2 bits per slot: 1 byte, 2 word, 3 long, 0 unmapped. An unmapped slot, or `req_size`=3, gives `rsp_err`=1 with no register-side access. By default, slot s has code 0 when s%4 is 3, and s%4+1 otherwise.
- R3: Size codes are 0 byte, 1 word and 2 long. A request equal to the native width makes exactly one register access of that width. Read data is right-justified in `rsp_rdata`.
- R4: A request wider than the slot makes size/native accesses of native width at offset, offset+native, and so on. Piece i carries the next most significant part of the data, big-endian. Read pieces are concatenated in the same order.
- R5: A read narrower than the slot makes one read of the aligned containing register. It returns the addressed bytes, where byte k of a container of n bytes occupies bits 8*(n-1-k)+7 down to 8*(n-1-k).
- R6: A write narrower than the slot makes one read and then one write of the containing register. The write leaves all non-addressed bytes unchanged.
- R7: `req_ready` is high only while the bridge is idle. The register side carries at most one access at a time. While `reg_valid` is high and `reg_ready` is low, `reg_addr`, `reg_size`, `reg_write` and `reg_wdata` hold.
- R8: `rsp_valid`, `rsp_err` and `rsp_rdata` hold until `rsp_ready`. Write and error responses return zero data.
- R9: During reset `req_ready`, `reg_valid` and `rsp_valid` are low.
- R10: Offset bits below the request size are ignored: the request is aligned down to its own size. Every register access is aligned to its own size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge accepts a request |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 illegal |
| req_off | input | 10 | Byte offset in the register window |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data, right-justified |
| reg_valid | output | 1 | Register access present |
| reg_ready | input | 1 | Register access completes this cycle |
| reg_write | output | 1 | Register access direction |
| reg_size | output | 2 | Native access size code |
| reg_addr | output | 10 | Register byte offset |
| reg_wdata | output | 32 | Register write data, right-justified |
| reg_rdata | input | 32 | Register read data, valid with reg_ready |

## Verification
The bench goes after the four-piece split of a long access on a byte slot. A bridge that reversed piece order or stepped the address wrongly would leave the bytes swapped in the register model and return scrambled read data. It writes a word into the low half of a long slot and a byte into an odd offset of a word slot. A wrong lane shift there corrupts neighbouring bytes, and a missing read-back phase zeroes them. It also sends requests at offset 0x200, to unmapped slots and with the illegal size code. A bridge that leaked any of these would show a register-side access count above zero or a clear error flag.

// File: rtl/width_bridge_pkg.sv
package width_bridge_pkg;

  localparam int SLOT_CNT   = 128;
  localparam int TABLE_BITS = 2 * SLOT_CNT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_XFER = 2'd2,
    ST_RESP = 2'd3
  } bridge_state_t;

  // slot code: 0 unmapped, 1 byte, 2 word, 3 long
  function automatic logic [TABLE_BITS-1:0] default_map();
    logic [TABLE_BITS-1:0] m;
    m = '0;
    for (int s = 0; s < SLOT_CNT; s++) begin
      m[2*s +: 2] = (s % 4 == 3) ? 2'd0 : 2'(s % 4 + 1);
    end
    return m;
  endfunction

endpackage

// File: rtl/width_bridge_lut.sv
module width_bridge_lut
  import width_bridge_pkg::*;
#(
  parameter int                    SLOT_W    = 7,
  parameter logic [TABLE_BITS-1:0] WIDTH_MAP = default_map()
) (
  input  logic [SLOT_W-1:0] slot,
  output logic [1:0]        code
);
  assign code = WIDTH_MAP[2*slot +: 2];
endmodule

// File: rtl/width_bridge_lane.sv
module width_bridge_lane #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rd,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        slg,
  input  logic [1:0]        nlg,
  input  logic [1:0]        k,
  input  logic [1:0]        rem,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] extracted,
  output logic [DATA_W-1:0] piece,
  output logic [DATA_W-1:0] acc_shift
);
  logic [5:0]          nb, sb, shift;
  logic [7:0]          pshift;
  logic [2*DATA_W-1:0] smask_w, nmask_w;
  logic [DATA_W-1:0]   smask, nmask, ins_mask;

  always_comb begin
    nb       = 6'd8 << nlg;
    sb       = 6'd8 << slg;
    shift    = nb - sb - {1'b0, k, 3'b000};
    smask_w  = ({{(2*DATA_W-1){1'b0}}, 1'b1} << sb) - 1'b1;
    nmask_w  = ({{(2*DATA_W-1){1'b0}}, 1'b1} << nb) - 1'b1;
    smask    = smask_w[DATA_W-1:0];
    nmask    = nmask_w[DATA_W-1:0];
    ins_mask = smask << shift;
    // read-modify-write: put the addressed lanes into the container
    merged    = (rd & ~ins_mask) | ((wdata & smask) << shift);
    extracted = (rd >> shift) & smask;
    // split: big-endian piece, most significant first
    pshift    = 8'(rem) * 8'(nb);
    piece     = (wdata >> pshift) & nmask;
    acc_shift = (acc << nb) | (rd & nmask);
  end
endmodule

// File: rtl/width_bridge.sv
module width_bridge
  import width_bridge_pkg::*;
#(
  parameter int                    OFF_W     = 10,
  parameter int                    DATA_W    = 32,
  parameter logic [TABLE_BITS-1:0] WIDTH_MAP = default_map()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_write,
  output logic [1:0]        reg_size,
  output logic [OFF_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int SLOT_W = $clog2(SLOT_CNT);
  localparam int LIMIT  = SLOT_CNT * 4;

  // reset release synchroniser
  logic [1:0] rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  logic run;
  assign run = rst_sync[1];

  bridge_state_t     st_q, st_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [1:0]        slg_q, slg_d, nlg_q, nlg_d, idx_q, idx_d;
  logic              wr_q, wr_d, rmw_q, rmw_d, err_q, err_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, acc_q, acc_d;

  // request decode
  logic [OFF_W-1:0]  off_al;
  logic [1:0]        code;
  logic              req_bad, accept;

  assign off_al = req_off & ({OFF_W{1'b1}} << req_size);

  width_bridge_lut #(.SLOT_W(SLOT_W), .WIDTH_MAP(WIDTH_MAP)) u_lut (
    .slot (off_al[SLOT_W+1:2]),
    .code (code)
  );

  assign req_bad = (req_size == 2'd3) || (32'(off_al) >= LIMIT) || (code == 2'd0);
  assign accept  = req_valid && req_ready;

  // sub-access addressing
  logic [OFF_W-1:0] cont_addr, step_addr;
  logic [1:0]       k, last_idx;
  logic [2:0]       cnt3;

  always_comb begin
    cont_addr = off_q & ({OFF_W{1'b1}} << nlg_q);
    k         = 2'(off_q - cont_addr);
    cnt3      = rmw_q ? 3'd1 : (3'd1 << (slg_q - nlg_q));
    last_idx  = 2'(cnt3 - 3'd1);
    step_addr = off_q + (OFF_W'(idx_q) << nlg_q);
  end

  logic [DATA_W-1:0] merged, extracted, piece, acc_shift;

  width_bridge_lane #(.DATA_W(DATA_W)) u_lane (
    .rd        (reg_rdata),
    .acc       (acc_q),
    .wdata     (wdata_q),
    .slg       (slg_q),
    .nlg       (nlg_q),
    .k         (k),
    .rem       (last_idx - idx_q),
    .merged    (merged),
    .extracted (extracted),
    .piece     (piece),
    .acc_shift (acc_shift)
  );

  // outputs
  assign req_ready = run && (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = (wr_q || err_q) ? '0 : acc_q;
  assign reg_valid = (st_q == ST_RD) || (st_q == ST_XFER);
  assign reg_size  = nlg_q;
  assign reg_write = (st_q == ST_XFER) && (rmw_q || wr_q);
  assign reg_addr  = rmw_q ? cont_addr : step_addr;
  assign reg_wdata = (st_q != ST_XFER) ? '0 : (rmw_q ? acc_q : (wr_q ? piece : '0));

  // next state
  always_comb begin
    st_d = st_q; off_d = off_q; slg_d = slg_q; nlg_d = nlg_q; idx_d = idx_q;
    wr_d = wr_q; rmw_d = rmw_q; err_d = err_q; wdata_d = wdata_q; acc_d = acc_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        off_d   = off_al;
        slg_d   = req_size;
        nlg_d   = code - 2'd1;
        wr_d    = req_write;
        wdata_d = req_wdata;
        idx_d   = 2'd0;
        acc_d   = '0;
        err_d   = req_bad;
        rmw_d   = !req_bad && (req_size < (code - 2'd1));
        st_d    = req_bad ? ST_RESP : ((req_size < (code - 2'd1)) ? ST_RD : ST_XFER);
      end
      ST_RD: if (reg_ready) begin
        acc_d = wr_q ? merged : extracted;
        st_d  = wr_q ? ST_XFER : ST_RESP;
      end
      ST_XFER: if (reg_ready) begin
        if (!rmw_q && !wr_q) acc_d = acc_shift;
        if (rmw_q || idx_q == last_idx) st_d = ST_RESP;
        else idx_d = idx_q + 2'd1;
      end
      ST_RESP: if (rsp_ready) begin
        st_d  = ST_IDLE;
        err_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; off_q <= '0; slg_q <= '0; nlg_q <= '0; idx_q <= '0;
      wr_q <= 1'b0; rmw_q <= 1'b0; err_q <= 1'b0; wdata_q <= '0; acc_q <= '0;
    end else begin
      st_q <= st_d; off_q <= off_d; slg_q <= slg_d; nlg_q <= nlg_d; idx_q <= idx_d;
      wr_q <= wr_d; rmw_q <= rmw_d; err_q <= err_d; wdata_q <= wdata_d; acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/width_bridge_chk.sv
module width_bridge_chk #(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 32,
  parameter int LIMIT  = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              reg_valid,
  input logic              reg_ready,
  input logic              reg_write,
  input logic [1:0]        reg_size,
  input logic [OFF_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_wdata
);
  // R1: no register access beyond the mapped window
  a_r1_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (32'(reg_addr) < LIMIT));

  // R2: illegal size never reaches the register side
  a_r2_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (reg_size != 2'd3));

  // R7: no new request while a sub-access is running
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> !req_ready);

  // R7: register access held while stalled
  a_r7_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_size)
                                   && $stable(reg_write) && $stable(reg_wdata)));

  // R8: response held until taken
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R10: every register access aligned to its size
  a_r10_reg_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> ((reg_addr & ~({OFF_W{1'b1}} << reg_size)) == '0));
endmodule

bind width_bridge width_bridge_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W),
                                     .LIMIT(width_bridge_pkg::SLOT_CNT * 4)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
  .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/width_bridge_test.sv
module width_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [9:0]  req_off;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        reg_valid, reg_ready, reg_write;
  logic [1:0]  reg_size;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int errors = 0, checks = 0;
  int n_acc = 0, bad_size = 0;
  logic [1:0] cur_nlg = 2'd0;
  logic timeout = 1'b0;
  logic [7:0] mem [0:511];
  logic [7:0] mem_ref [0:511];

  always #2 clk = ~clk;

  width_bridge uut (.*);

  // register block model
  always_comb begin
    reg_rdata = '0;
    for (int j = 0; j < 4; j++)
      if (j < (1 << reg_size)) reg_rdata = (reg_rdata << 8) | 32'(mem[9'(reg_addr + 10'(j))]);
  end

  always @(posedge clk) begin
    if (rst_n && reg_valid && reg_ready) begin
      n_acc <= n_acc + 1;
      if (reg_size != cur_nlg) bad_size <= bad_size + 1;
      if (reg_write)
        for (int j = 0; j < 4; j++)
          if (j < (1 << reg_size))
            mem[9'(reg_addr + 10'(j))] <= reg_wdata[8*((1 << reg_size) - 1 - j) +: 8];
    end
  end

  always @(negedge clk) reg_ready <= ($urandom % 3) != 0;

  function automatic logic [1:0] slot_code(int slot);
    return (slot % 4 == 3) ? 2'd0 : 2'(slot % 4 + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(string req, logic wr, logic [1:0] sz, logic [9:0] off, logic [31:0] wd,
                     logic chk_busy);
    int al, sb, nb, exp_cnt, acc0, bs0, dly, mism;
    logic [1:0] code;
    logic err_exp;
    logic [31:0] exp_rd, held;
    al   = int'(off) & ~((1 << sz) - 1);
    code = (al < 512) ? slot_code(al >> 2) : 2'd0;
    err_exp = (sz == 2'd3) || (al >= 512) || (code == 2'd0);
    sb = 1 << sz;
    nb = err_exp ? 1 : (1 << (code - 1));
    cur_nlg = code - 2'd1;
    exp_cnt = err_exp ? 0 : (sb > nb ? sb / nb : (sb < nb ? (wr ? 2 : 1) : 1));
    exp_rd = '0;
    if (!err_exp) begin
      for (int j = 0; j < sb; j++) begin
        exp_rd = (exp_rd << 8) | 32'(mem_ref[al + j]);
        if (wr) mem_ref[al + j] = wd[8*(sb - 1 - j) +: 8];
      end
    end
    if (wr || err_exp) exp_rd = '0;
    acc0 = n_acc; bs0 = bad_size;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_off = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_busy) check("R7 req_ready low while busy", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    dly = $urandom % 3;
    repeat (dly) @(negedge clk);
    if (dly > 0) check("R8 rdata held", rsp_rdata, held);
    check({req, " err"}, 32'(rsp_err), 32'(err_exp));
    check({req, " rdata"}, rsp_rdata, exp_rd);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({req, " access count"}, 32'(n_acc - acc0), 32'(exp_cnt));
    check({req, " access size"}, 32'(bad_size - bs0), 32'd0);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== mem_ref[i]) mism++;
    check({req, " register contents"}, 32'(mism), 32'd0);
  endtask

  task automatic run_all();
    logic [1:0] sz;
    for (int i = 0; i < 512; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      mem[i] <= v;
      mem_ref[i] = v;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = '0;
    req_off = '0; req_wdata = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 req_ready in reset", 32'(req_ready), 32'd0);
    check("R9 reg_valid in reset", 32'(reg_valid), 32'd0);
    check("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed corners
    txn("R3 long read on long slot", 1'b0, 2'd2, 10'h008, 32'h0, 1'b1);
    txn("R4 long write on byte slot", 1'b1, 2'd2, 10'h010, 32'hA1B2C3D4, 1'b0);
    txn("R4 long read on byte slot", 1'b0, 2'd2, 10'h010, 32'h0, 1'b0);
    txn("R4 long write on word slot", 1'b1, 2'd2, 10'h014, 32'h11223344, 1'b0);
    txn("R4 word read on byte slot", 1'b0, 2'd1, 10'h012, 32'h0, 1'b0);
    txn("R6 word write low half of long slot", 1'b1, 2'd1, 10'h01A, 32'h0000BEEF, 1'b0);
    txn("R6 byte write odd in word slot", 1'b1, 2'd0, 10'h025, 32'h0000005A, 1'b0);
    txn("R5 byte read offset 3 of long slot", 1'b0, 2'd0, 10'h01B, 32'h0, 1'b0);
    txn("R5 word read upper half of long slot", 1'b0, 2'd1, 10'h018, 32'h0, 1'b0);
    txn("R1 offset 0x200", 1'b1, 2'd0, 10'h200, 32'h000000FF, 1'b0);
    txn("R1 offset 0x3FF", 1'b0, 2'd2, 10'h3FF, 32'h0, 1'b0);
    txn("R2 unmapped slot", 1'b1, 2'd2, 10'h00C, 32'hDEADBEEF, 1'b0);
    txn("R2 size code 3", 1'b1, 2'd3, 10'h008, 32'hDEADBEEF, 1'b0);
    txn("R10 misaligned long", 1'b1, 2'd2, 10'h00B, 32'hCAFEF00D, 1'b0);
    txn("R10 misaligned word read", 1'b0, 2'd1, 10'h015, 32'h0, 1'b0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      sz = (($urandom % 16) == 0) ? 2'd3 : 2'($urandom % 3);
      txn("R3 R4 R5 R6 random", 1'($urandom), sz,
          (($urandom % 8) == 0) ? 10'($urandom) : 10'($urandom % 512), $urandom, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule